// File: doc/BRIEF.md
# Iterative RC6 Encryption Core

This block turns one 128-bit plaintext block into one 128-bit ciphertext block with the RC6 cipher at 32-bit words and 20 rounds. The four 32-bit working words sit in a single register set. One round is evaluated per clock, and the result is written back into that same register set. Round keys are not generated inside the block. The core fetches them, already expanded, from an outside key store. It drives the address of the pair it needs in each cycle and expects the matching pair on the key input within the same cycle.

A block is taken when `in_valid` is high while `in_ready` is high. `in_ready` stays low until the ciphertext is out, so a caller working in a feedback chaining mode can feed the last ciphertext straight back in. The caller may present that new block in the same cycle that `done` pulses. The result stays on `data_out` until the next block completes.

Top module: `rc6_iter_core`

## Requirements
- R1: While reset is held and in the first cycle after it, `in_ready` is 1, `done` is 0 and `data_out` is all zero.
- R2: A block is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the edge after acceptance until the cycle in which `done` is 1. With `in_valid` low the core stays idle and `done` stays 0.
- R3: While a block is in flight, `in_valid` and `data_in` are ignored. The ciphertext produced is that of the block that was accepted.
- R4: `key_index` selects a key pair k from 0 to 21, and `key_word` must then carry S[2k] in bits 31:0 and S[2k+1] in bits 63:32. Over the 22 busy cycles after acceptance, `key_index` counts 0, 1, …, 21, one step per cycle.
- R5: In the first busy cycle, word B gets S[0] added and word D gets S[1] added, both modulo 2^32.
- R6: Each of the 20 round cycles i computes t = rotl(B·(2B+1), 5) and u = rotl(D·(2D+1), 5). It then computes A' = rotl(A^t, u mod 32) + S[2i] and C' = rotl(C^u, t mod 32) + S[2i+1]. The new words are (A,B,C,D) = (B,C',D,A').
- R7: In the last busy cycle, word A gets S[42] added and word C gets S[43] added.
- R8: Word A is `data_in[31:0]`, B is `[63:32]`, C is `[95:64]` and D is `[127:96]`. `data_out` uses the same layout. An all-zero key with all-zero plaintext gives D,C,B,A = 1ea44898_4edf29c1_78f7b156_36a5c38f.
- R9: `done` is high for exactly one cycle, 22 clock edges after the accepting edge.
- R10: `data_out` changes only in the cycle `done` goes high and holds its value otherwise.
- R11: A new block may be accepted in the same cycle `done` is high. That allows back-to-back chained blocks with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Plaintext block offered |
| in_ready | output | 1 | Core idle and able to take a block |
| data_in | input | 128 | Plaintext, word A in the low 32 bits |
| key_index | output | 5 | Round-key pair currently addressed (0..21) |
| key_word | input | 64 | Addressed pair: even key low, odd key high |
| done | output | 1 | One-cycle pulse when the ciphertext is valid |
| data_out | output | 128 | Ciphertext of the last finished block, held |

## Verification
The bench goes after the data-dependent rotation amounts. These include amounts of zero and of 31. A rotate that is wrong in those cases, or that uses the wrong source for its amount, gives ciphertexts that differ from the reference model and from the known all-zero vector. The bench also offers a second block mid-flight. A core that does not hold off would corrupt its working words or finish early. Chained back-to-back blocks check that a core taking its next block in the `done` cycle neither drops it nor stalls. A key pair off by one in the address sequence, or a swapped even/odd half, shows up as a wrong `key_index` in a given cycle or as a wrong ciphertext.

// File: rtl/rc6_pkg.sv
package rc6_pkg;

    localparam int WORD_W   = 32;
    localparam int ROUNDS   = 20;
    localparam int KPAIRS   = ROUNDS + 2;
    localparam int KIDX_W   = $clog2(KPAIRS);
    localparam int ROT_W    = $clog2(WORD_W);
    localparam int CNT_W    = $clog2(ROUNDS + 1);
    localparam int LATENCY  = ROUNDS + 2;
    localparam int BLK_W    = 4 * WORD_W;

    typedef logic [WORD_W-1:0] word_t;

    // last member lands in the least significant bits: word a is the low word
    typedef struct packed {
        word_t d;
        word_t c;
        word_t b;
        word_t a;
    } blk_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PRE,
        PH_RND,
        PH_POST
    } phase_e;

    function automatic word_t rotl(input word_t x, input logic [ROT_W-1:0] s);
        logic [2*WORD_W-1:0] dbl;
        dbl = {x, x} << s;
        return dbl[2*WORD_W-1:WORD_W];
    endfunction

    function automatic word_t quad(input word_t x);
        word_t odd2;
        word_t prod;
        odd2 = {x[WORD_W-2:0], 1'b1};
        prod = x * odd2;
        return prod;
    endfunction

endpackage

// File: rtl/rc6_round.sv
module rc6_round
    import rc6_pkg::*;
(
    input  blk_t  cur,
    input  word_t k_even,
    input  word_t k_odd,
    output blk_t  nxt
);
    localparam logic [ROT_W-1:0] FIXED_ROT = ROT_W'(ROT_W);

    word_t t_mix;
    word_t u_mix;
    word_t a_new;
    word_t c_new;

    always_comb begin
        t_mix = rotl(quad(cur.b), FIXED_ROT);
        u_mix = rotl(quad(cur.d), FIXED_ROT);
        a_new = rotl(cur.a ^ t_mix, u_mix[ROT_W-1:0]) + k_even;
        c_new = rotl(cur.c ^ u_mix, t_mix[ROT_W-1:0]) + k_odd;
        nxt.a = cur.b;
        nxt.b = c_new;
        nxt.c = cur.d;
        nxt.d = a_new;
    end
endmodule

// File: rtl/rc6_whiten.sv
module rc6_whiten
    import rc6_pkg::*;
#(
    parameter bit POST = 1'b0
) (
    input  blk_t  cur,
    input  word_t k_even,
    input  word_t k_odd,
    output blk_t  nxt
);
    generate
        if (POST) begin : g_post
            always_comb begin
                nxt   = cur;
                nxt.a = cur.a + k_even;
                nxt.c = cur.c + k_odd;
            end
        end else begin : g_pre
            always_comb begin
                nxt   = cur;
                nxt.b = cur.b + k_even;
                nxt.d = cur.d + k_odd;
            end
        end
    endgenerate
endmodule

// File: rtl/rc6_ctrl.sv
module rc6_ctrl
    import rc6_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output phase_e            phase,
    output logic              accept,
    output logic              in_ready,
    output logic [KIDX_W-1:0] kidx
);
    phase_e            phase_q;
    logic [CNT_W-1:0]  rnd_q;

    assign phase    = phase_q;
    assign in_ready = (phase_q == PH_IDLE);
    assign accept   = in_ready && in_valid;

    always_comb begin
        unique case (phase_q)
            PH_RND:  kidx = KIDX_W'(rnd_q);
            PH_POST: kidx = KIDX_W'(KPAIRS - 1);
            default: kidx = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            rnd_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: if (accept) phase_q <= PH_PRE;
                PH_PRE: begin
                    phase_q <= PH_RND;
                    rnd_q   <= CNT_W'(1);
                end
                PH_RND: begin
                    if (rnd_q == CNT_W'(ROUNDS)) begin
                        phase_q <= PH_POST;
                        rnd_q   <= '0;
                    end else begin
                        rnd_q <= rnd_q + CNT_W'(1);
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // R2: busy core never reports ready
    a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE) |-> !in_ready);

    // R4: key pair address stays within the 22 stored pairs
    a_r4_kidx_range: assert property (@(posedge clk) disable iff (rst)
        kidx < KIDX_W'(KPAIRS));

    // R4: address advances by one each busy cycle after the first
    a_r4_kidx_step: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE && phase_q != PH_PRE) |->
            kidx == $past(kidx) + KIDX_W'(1));
endmodule

// File: rtl/rc6_iter_core.sv
module rc6_iter_core
    import rc6_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [BLK_W-1:0]       data_in,
    output logic [KIDX_W-1:0]      key_index,
    input  logic [2*WORD_W-1:0]    key_word,
    output logic                   done,
    output logic [BLK_W-1:0]       data_out
);
    localparam int LCNT_W = $clog2(LATENCY + 2);

    phase_e phase;
    logic   accept;
    blk_t   blk_q;
    blk_t   pre_nxt;
    blk_t   rnd_nxt;
    blk_t   post_nxt;
    word_t  k_even;
    word_t  k_odd;
    logic   done_q;
    blk_t   out_q;

    assign k_even = key_word[WORD_W-1:0];
    assign k_odd  = key_word[2*WORD_W-1:WORD_W];

    rc6_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .phase    (phase),
        .accept   (accept),
        .in_ready (in_ready),
        .kidx     (key_index)
    );

    rc6_whiten #(.POST(1'b0)) u_pre (
        .cur(blk_q), .k_even(k_even), .k_odd(k_odd), .nxt(pre_nxt)
    );

    rc6_round u_round (
        .cur(blk_q), .k_even(k_even), .k_odd(k_odd), .nxt(rnd_nxt)
    );

    rc6_whiten #(.POST(1'b1)) u_post (
        .cur(blk_q), .k_even(k_even), .k_odd(k_odd), .nxt(post_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_q  <= '0;
            out_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase)
                PH_IDLE: if (accept) blk_q <= blk_t'(data_in);
                PH_PRE:  blk_q <= pre_nxt;
                PH_RND:  blk_q <= rnd_nxt;
                default: begin
                    out_q  <= post_nxt;
                    done_q <= 1'b1;
                end
            endcase
        end
    end

    assign done     = done_q;
    assign data_out = out_q;

    // checker: cycles elapsed since the last accepted block, saturating
    logic [LCNT_W-1:0] since_acc;
    always_ff @(posedge clk) begin
        if (rst)
            since_acc <= '1;
        else if (accept)
            since_acc <= '0;
        else if (since_acc != '1)
            since_acc <= since_acc + LCNT_W'(1);
    end

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: done appears exactly LATENCY edges after acceptance
    a_r9_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> since_acc == LCNT_W'(LATENCY));

    // R10: ciphertext held between completions
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(data_out));

    // R11: ready is back in the cycle the result is announced
    a_r11_ready_at_done: assert property (@(posedge clk) disable iff (rst)
        done |-> in_ready);
endmodule

// File: tb/rc6_iter_core_tb.sv
module rc6_iter_core_tb_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic [127:0] data_in;
    logic [4:0]   key_index;
    logic [63:0]  key_word;
    logic         done;
    logic [127:0] data_out;

    logic [31:0]  sk [0:43];
    int           n_tests = 0;
    int           n_fail  = 0;
    bit           finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rc6_iter_core dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .data_in(data_in), .key_index(key_index), .key_word(key_word),
        .done(done), .data_out(data_out)
    );

    // external key store: pair k = {S[2k+1], S[2k]}
    always_comb begin
        if (int'(key_index) < 22)
            key_word = {sk[2*int'(key_index)+1], sk[2*int'(key_index)]};
        else
            key_word = '0;
    end

    function automatic logic [31:0] b_rotl(input logic [31:0] x, input int s);
        int m;
        m = s % 32;
        if (m == 0) return x;
        return (x << m) | (x >> (32 - m));
    endfunction

    task automatic make_keys(input logic [127:0] ukey);
        logic [31:0] lw [0:3];
        logic [31:0] x, y;
        int ii, jj;
        for (int k = 0; k < 4; k++) lw[k] = ukey[32*k +: 32];
        sk[0] = 32'hb7e15163;
        for (int k = 1; k < 44; k++) sk[k] = sk[k-1] + 32'h9e3779b9;
        x = 0; y = 0; ii = 0; jj = 0;
        for (int s = 0; s < 132; s++) begin
            sk[ii] = b_rotl(sk[ii] + x + y, 3);
            x = sk[ii];
            lw[jj] = b_rotl(lw[jj] + x + y, int'((x + y) & 32'd31));
            y = lw[jj];
            ii = (ii + 1) % 44;
            jj = (jj + 1) % 4;
        end
    endtask

    function automatic logic [127:0] ref_enc(input logic [127:0] pt);
        logic [31:0] a, b, c, d, t, u, tmp;
        a = pt[31:0]; b = pt[63:32]; c = pt[95:64]; d = pt[127:96];
        b = b + sk[0];
        d = d + sk[1];
        for (int i = 1; i <= 20; i++) begin
            t = b_rotl(b * (2*b + 1), 5);
            u = b_rotl(d * (2*d + 1), 5);
            a = b_rotl(a ^ t, int'(u[4:0])) + sk[2*i];
            c = b_rotl(c ^ u, int'(t[4:0])) + sk[2*i+1];
            tmp = a; a = b; b = c; c = d; d = tmp;
        end
        a = a + sk[42];
        c = c + sk[43];
        return {d, c, b, a};
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // called at a negedge with the core idle: offer a block for one edge
    task automatic start_blk(input logic [127:0] pt);
        in_valid = 1'b1;
        data_in  = pt;
        chk(in_ready == 1'b1, "R2 ready before accept", 128'(in_ready), 128'd1);
        @(negedge clk);
        in_valid = 1'b0;
        data_in  = '0;
    endtask

    // starts at the negedge after the accepting edge; ends at done negedge
    task automatic finish_blk(input logic [127:0] exp, input bit inject);
        for (int k = 0; k < 22; k++) begin
            chk(key_index == 5'(k), "R4 key pair address", 128'(key_index), 128'(k));
            chk(done == 1'b0, "R9 no early done", 128'(done), 128'd0);
            chk(in_ready == 1'b0, "R2 busy not ready", 128'(in_ready), 128'd0);
            if (inject && k == 5) begin
                in_valid = 1'b1;
                data_in  = {4{32'hdeadbeef}};
            end
            if (inject && k == 7) begin
                in_valid = 1'b0;
                data_in  = '0;
            end
            @(negedge clk);
        end
        chk(done == 1'b1, "R9 done after 22 edges", 128'(done), 128'd1);
        chk(in_ready == 1'b1, "R11 ready at done", 128'(in_ready), 128'd1);
        chk(data_out == exp, "R5 R6 R7 ciphertext", data_out, exp);
    endtask

    initial begin
        logic [127:0] pt, exp, prev;
        rst = 1'b1; in_valid = 1'b0; data_in = '0;
        make_keys('0);
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1, "R1 reset ready", 128'(in_ready), 128'd1);
        chk(done == 1'b0, "R1 reset done", 128'(done), 128'd0);
        chk(data_out == '0, "R1 reset data", data_out, '0);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1 && done == 1'b0 && data_out == '0,
            "R1 after reset", data_out, '0);

        // R2: idle with no valid
        repeat (4) begin
            @(negedge clk);
            chk(done == 1'b0 && in_ready == 1'b1, "R2 idle stays idle",
                128'(done), 128'd0);
        end

        // R8: all-zero key and plaintext, known ciphertext
        exp = ref_enc('0);
        start_blk('0);
        finish_blk(exp, 1'b0);
        chk(data_out == 128'h1ea44898_4edf29c1_78f7b156_36a5c38f,
            "R8 known vector", data_out, 128'h1ea44898_4edf29c1_78f7b156_36a5c38f);
        @(negedge clk);
        chk(done == 1'b0, "R9 pulse one cycle", 128'(done), 128'd0);

        // R3 + R10: random key, offer a second block mid-flight, then hold
        make_keys({$urandom, $urandom, $urandom, $urandom});
        pt  = {$urandom, $urandom, $urandom, $urandom};
        exp = ref_enc(pt);
        start_blk(pt);
        finish_blk(exp, 1'b1);
        chk(data_out == exp, "R3 busy input ignored", data_out, exp);
        for (int w = 0; w < 6; w++) begin
            @(negedge clk);
            chk(data_out == exp && done == 1'b0, "R10 output held", data_out, exp);
        end

        // R11: chained back-to-back blocks, new key per chain
        for (int chain = 0; chain < 4; chain++) begin
            make_keys({$urandom, $urandom, $urandom, $urandom});
            prev = {$urandom, $urandom, $urandom, $urandom};
            start_blk(prev);
            for (int blk = 0; blk < 3; blk++) begin
                exp = ref_enc(prev);
                finish_blk(exp, 1'b0);
                prev = data_out;
                if (blk < 2) start_blk(prev);
            end
            @(negedge clk);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule